// File: doc/BRIEF.md
# Four-Lane Jitter and Crosstalk Stress Packet Sequencer

This block produces a repeating stress packet on a four-lane, column-wide transmit path. Each column carries one byte and one control flag per lane. A packet opens with a start column and a preamble column ending in the frame delimiter. The body follows: a disparity-steering column, then the stress core (sent once or twice), then a fixed check column. A three-column gap closes the packet.

The core is deliberately lane-staggered. Lanes 3 and 1 run a sparse-transition section first and a dense one second, while lanes 2 and 0 run them the other way round. This keeps adjacent lanes from switching in phase. The per-lane steering bytes and the odd-length gap shift the relative running disparity from one repeat to the next. Line coding, disparity tracking and check-sum arithmetic belong to other blocks.

A `ready_i` handshake lets downstream logic stall the stream without losing or duplicating columns. The sequencer runs in two modes: single-shot, or continuous repeat with no idle between packets. A short/long select picks one of two packet forms. The select is captured at the start of each packet.

Top module: `jps_lane_stress_seq`

## Requirements
- R1: Out of reset, and whenever no packet is in flight, every column is an idle column: byte 0x1C in all lanes and all four control flags set. `busy_o` and `done_o` are low.
- R2: A high `start_i` while idle puts the start column on the outputs at the next clock edge. In that column lane 0 holds 0xFB with only its flag set, and lanes 1 to 3 hold 0x55. The preamble column follows: 0x55 in lanes 0 to 2, 0xD5 in lane 3, and all flags clear. Lane n occupies `col_data_o[8n+7:8n]` and `col_ctrl_o[n]`.
- R3: After the preamble comes one steering column. In the long form (`short_i`=0) it is 0x55000707 (lanes 3..0). In the short form it is 0x55550707.
- R4: The core is 188 columns, written as lanes 3..0. It opens with 7EB57EB5 ×40. Next are 8 columns that alternate 7EEB7EEB and 7EF47EF4, starting with EB. Then comes 7E7E7E7E ×84. Then 7 columns alternate F47EF47E and EB7EEB7E, starting with F4. These are followed by AB7EAB7E once and B57EB57E ×40. Then 7 columns alternate EBF4EBF4 and F4EBF4EB, starting with EB. The core ends with F4ABF4AB.
- R5: The long form sends the core twice back to back and then the check column 0xDD09AE5B. The short form sends it once and then 0xCC0809CA. A change of `short_i` in the middle of a packet has no effect on that packet.
- R6: The start, preamble, steering, core and check columns are data columns apart from lane 0 of the start column, and their other control flags are all clear.
- R7: The gap is three columns, all with every flag set. The first has 0xBC in lanes 3..1 and 0xFD in lane 0. The second has 0x7C in every lane. The third has 0x1C in every lane.
- R8: While `ready_i` is low during a packet, the column on the outputs holds unchanged. Each column is presented until accepted, is accepted exactly once, and none is skipped.
- R9: If `repeat_i` is high when the last gap column is accepted, the next start column follows at the very next edge. Otherwise the block returns to idle.
- R10: `done_o` is high in exactly the cycles in which the last gap column is accepted, and nowhere else.
- R11: `busy_o` is high from the start column through the last gap column. A long packet is 383 columns and a short packet 195.
- R12: `short_i` is sampled when a packet begins, whether from idle or at a repeat boundary. It then holds for the whole packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet when idle |
| short_i | input | 1 | 1 selects the short packet form, 0 the long form |
| repeat_i | input | 1 | Continue with another packet after the gap |
| ready_i | input | 1 | Downstream accepts the current column |
| col_data_o | output | 32 | Column bytes, lane n in bits 8n+7:8n |
| col_ctrl_o | output | 4 | Per-lane control flags, lane n in bit n |
| busy_o | output | 1 | A packet is in flight |
| done_o | output | 1 | Last gap column is being accepted |

## Verification
The run-length counter, table index and core pass flag are visible only through the column stream. A wrong count or index puts a wrong byte on some lane as soon as the faulty column is accepted. A slip of one column moves every later value, so the scoreboard catches it within the same run. A stale mode bit or pass flag shows up at the steering column, at the boundary where the core would repeat, or at the check column. A wrong phase shows up as a missing or extra control flag, or as `busy_o` or `done_o` in the wrong cycle. Random stalls test the hold behaviour, since any state that advances without acceptance changes the held column at the next sample.

// File: rtl/jps_pkg.sv
package jps_pkg;

    localparam int LANES      = 4;
    localparam int LANE_W     = 8;
    localparam int COL_W      = LANES * LANE_W;
    localparam int CORE_ENTS  = 8;
    localparam int ENT_W      = $clog2(CORE_ENTS);
    localparam int RUN_MAX    = 84;
    localparam int RUN_W      = $clog2(RUN_MAX + 1);
    localparam int GAP_COLS   = 3;
    localparam int SUB_W      = 2;

    localparam logic [LANE_W-1:0] B_IDLE  = 8'h1C;
    localparam logic [LANE_W-1:0] B_ALIGN = 8'h7C;
    localparam logic [LANE_W-1:0] B_COMMA = 8'hBC;
    localparam logic [LANE_W-1:0] B_TERM  = 8'hFD;
    localparam logic [LANE_W-1:0] B_START = 8'hFB;
    localparam logic [LANE_W-1:0] B_PRE   = 8'h55;
    localparam logic [LANE_W-1:0] B_SFD   = 8'hD5;

    localparam logic [COL_W-1:0] STEER_LONG  = 32'h5500_0707;
    localparam logic [COL_W-1:0] STEER_SHORT = 32'h5555_0707;
    localparam logic [COL_W-1:0] CHECK_LONG  = 32'hDD09_AE5B;
    localparam logic [COL_W-1:0] CHECK_SHORT = 32'hCC08_09CA;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_STEER,
        PH_CORE,
        PH_CHECK,
        PH_GAP
    } phase_e;

    // One run of the core: column on even steps, column on odd steps, length
    typedef struct packed {
        logic [COL_W-1:0] col_even;
        logic [COL_W-1:0] col_odd;
        logic [RUN_W-1:0] run;
    } core_ent_t;

    typedef struct packed {
        phase_e           phase;
        logic [SUB_W-1:0] sub;
        logic [ENT_W-1:0] ent;
        logic [RUN_W-1:0] cnt;
        logic             pass;
        logic             short_m;
    } seq_st_t;

    function automatic core_ent_t core_lookup(input logic [ENT_W-1:0] idx);
        core_ent_t e;
        unique case (idx)
            3'd0:    e = '{col_even: 32'h7EB5_7EB5, col_odd: 32'h7EB5_7EB5, run: RUN_W'(40)};
            3'd1:    e = '{col_even: 32'h7EEB_7EEB, col_odd: 32'h7EF4_7EF4, run: RUN_W'(8)};
            3'd2:    e = '{col_even: 32'h7E7E_7E7E, col_odd: 32'h7E7E_7E7E, run: RUN_W'(84)};
            3'd3:    e = '{col_even: 32'hF47E_F47E, col_odd: 32'hEB7E_EB7E, run: RUN_W'(7)};
            3'd4:    e = '{col_even: 32'hAB7E_AB7E, col_odd: 32'hAB7E_AB7E, run: RUN_W'(1)};
            3'd5:    e = '{col_even: 32'hB57E_B57E, col_odd: 32'hB57E_B57E, run: RUN_W'(40)};
            3'd6:    e = '{col_even: 32'hEBF4_EBF4, col_odd: 32'hF4EB_F4EB, run: RUN_W'(7)};
            default: e = '{col_even: 32'hF4AB_F4AB, col_odd: 32'hF4AB_F4AB, run: RUN_W'(1)};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/jps_core_rom.sv
module jps_core_rom
    import jps_pkg::*;
(
    input  logic [ENT_W-1:0] idx_i,
    input  logic [RUN_W-1:0] step_i,
    output logic [COL_W-1:0] col_o,
    output logic [RUN_W-1:0] run_o
);
    core_ent_t ent;

    always_comb begin
        ent   = core_lookup(idx_i);
        run_o = ent.run;
        col_o = step_i[0] ? ent.col_odd : ent.col_even;
    end

endmodule

// File: rtl/jps_col_fmt.sv
module jps_col_fmt
    import jps_pkg::*;
(
    input  phase_e           phase_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             short_i,
    input  logic [COL_W-1:0] core_col_i,
    output logic [COL_W-1:0] data_o,
    output logic [LANES-1:0] ctrl_o
);
    logic [LANE_W-1:0] gap_byte [LANES];

    // Control-character lane bytes of the gap columns, built per lane
    for (genvar l = 0; l < LANES; l++) begin : g_gap_lane
        always_comb begin
            unique case (sub_i)
                2'd0:    gap_byte[l] = (l == 0) ? B_TERM : B_COMMA;
                2'd1:    gap_byte[l] = B_ALIGN;
                default: gap_byte[l] = B_IDLE;
            endcase
        end
    end

    always_comb begin
        data_o = {LANES{B_IDLE}};
        ctrl_o = '1;
        unique case (phase_i)
            PH_PRE: begin
                if (sub_i == '0) begin
                    data_o = {{(LANES-1){B_PRE}}, B_START};
                    ctrl_o = {{(LANES-1){1'b0}}, 1'b1};
                end else begin
                    data_o = {B_SFD, {(LANES-1){B_PRE}}};
                    ctrl_o = '0;
                end
            end
            PH_STEER: begin
                data_o = short_i ? STEER_SHORT : STEER_LONG;
                ctrl_o = '0;
            end
            PH_CORE: begin
                data_o = core_col_i;
                ctrl_o = '0;
            end
            PH_CHECK: begin
                data_o = short_i ? CHECK_SHORT : CHECK_LONG;
                ctrl_o = '0;
            end
            PH_GAP: begin
                for (int l = 0; l < LANES; l++) begin
                    data_o[l*LANE_W +: LANE_W] = gap_byte[l];
                end
                ctrl_o = '1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/jps_lane_stress_seq.sv
module jps_lane_stress_seq
    import jps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        short_i,
    input  logic        repeat_i,
    input  logic        ready_i,
    output logic [31:0] col_data_o,
    output logic [3:0]  col_ctrl_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(CORE_ENTS - 1);
    localparam logic [SUB_W-1:0] GAP_LAST = SUB_W'(GAP_COLS - 1);
    localparam seq_st_t IDLE_ST = '{phase: PH_IDLE, sub: '0, ent: '0, cnt: '0,
                                    pass: 1'b0, short_m: 1'b0};

    seq_st_t          st_q, st_d;
    logic             accept;
    logic             run_end;
    logic [COL_W-1:0] core_col;
    logic [RUN_W-1:0] run_len;

    jps_core_rom u_rom (
        .idx_i  (st_q.ent),
        .step_i (st_q.cnt),
        .col_o  (core_col),
        .run_o  (run_len)
    );

    jps_col_fmt u_fmt (
        .phase_i    (st_q.phase),
        .sub_i      (st_q.sub),
        .short_i    (st_q.short_m),
        .core_col_i (core_col),
        .data_o     (col_data_o),
        .ctrl_o     (col_ctrl_o)
    );

    always_comb begin
        st_d    = st_q;
        accept  = ready_i && (st_q.phase != PH_IDLE);
        run_end = (st_q.cnt == run_len - RUN_W'(1));
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase   = PH_PRE;
                    st_d.sub     = '0;
                    st_d.short_m = short_i;
                end
            end
            PH_PRE: begin
                if (accept) begin
                    if (st_q.sub == '0) begin
                        st_d.sub = SUB_W'(1);
                    end else begin
                        st_d.phase = PH_STEER;
                        st_d.sub   = '0;
                    end
                end
            end
            PH_STEER: begin
                if (accept) begin
                    st_d.phase = PH_CORE;
                    st_d.ent   = '0;
                    st_d.cnt   = '0;
                    st_d.pass  = 1'b0;
                end
            end
            PH_CORE: begin
                if (accept) begin
                    if (run_end) begin
                        st_d.cnt = '0;
                        if (st_q.ent == LAST_ENT) begin
                            st_d.ent = '0;
                            if (!st_q.short_m && !st_q.pass) begin
                                st_d.pass = 1'b1;
                            end else begin
                                st_d.phase = PH_CHECK;
                                st_d.pass  = 1'b0;
                            end
                        end else begin
                            st_d.ent = st_q.ent + ENT_W'(1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + RUN_W'(1);
                    end
                end
            end
            PH_CHECK: begin
                if (accept) begin
                    st_d.phase = PH_GAP;
                    st_d.sub   = '0;
                end
            end
            PH_GAP: begin
                if (accept) begin
                    if (st_q.sub == GAP_LAST) begin
                        st_d.sub = '0;
                        if (repeat_i) begin
                            st_d.phase   = PH_PRE;
                            st_d.short_m = short_i;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end else begin
                        st_d.sub = st_q.sub + SUB_W'(1);
                    end
                end
            end
            default: st_d = IDLE_ST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IDLE_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign done_o = accept && (st_q.phase == PH_GAP) && (st_q.sub == GAP_LAST);

    AST_IDLE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (col_ctrl_o == 4'hF && col_data_o == 32'h1C1C_1C1C)); // R1

    AST_BODY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CORE || st_q.phase == PH_STEER || st_q.phase == PH_CHECK)
        |-> (col_ctrl_o == 4'h0)); // R6

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CORE) |-> (st_q.cnt < run_len)); // R4

    AST_SECOND_PASS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pass |-> !st_q.short_m); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ready_i) |=> ($stable(col_data_o) && $stable(col_ctrl_o))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && col_ctrl_o == 4'hF && col_data_o == 32'h1C1C_1C1C)); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(st_q.phase == PH_PRE && st_q.sub == '0)) |-> $stable(st_q.short_m)); // R12

endmodule

// File: tb/jps_lane_stress_seq_tb.sv
`timescale 1ns/1ps
module jps_lane_stress_seq_tb;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  c;
        bit          last;
        int          req;
    } col_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        short_i = 1'b0;
    logic        repeat_i = 1'b0;
    logic        ready_i = 1'b1;
    logic [31:0] col_data_o;
    logic [3:0]  col_ctrl_o;
    logic        busy_o;
    logic        done_o;

    int   total = 0;
    int   bad = 0;
    bit   mon_en = 1'b0;
    bit   stall_en = 1'b0;
    bit   finished = 1'b0;
    col_t q[$];

    always #2 clk = ~clk;

    jps_lane_stress_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .short_i    (short_i),
        .repeat_i   (repeat_i),
        .ready_i    (ready_i),
        .col_data_o (col_data_o),
        .col_ctrl_o (col_ctrl_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input int req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input logic [31:0] d, input logic [3:0] c, input int req);
        col_t it;
        it.d = d; it.c = c; it.last = 1'b0; it.req = req;
        q.push_back(it);
    endtask

    task automatic put_run(input logic [31:0] a, input logic [31:0] b, input int n);
        for (int i = 0; i < n; i++) put((i % 2 == 1) ? b : a, 4'h0, 4); // R4
    endtask

    // Driver: expected columns of one packet, from the requirements
    task automatic push_pkt(input bit shrt);
        col_t it;
        put(32'h5555_55FB, 4'h1, 2);                          // R2
        put(32'hD555_5555, 4'h0, 2);                          // R2
        put(shrt ? 32'h5555_0707 : 32'h5500_0707, 4'h0, 3);   // R3
        for (int p = 0; p < (shrt ? 1 : 2); p++) begin
            put_run(32'h7EB5_7EB5, 32'h7EB5_7EB5, 40);
            put_run(32'h7EEB_7EEB, 32'h7EF4_7EF4, 8);
            put_run(32'h7E7E_7E7E, 32'h7E7E_7E7E, 84);
            put_run(32'hF47E_F47E, 32'hEB7E_EB7E, 7);
            put_run(32'hAB7E_AB7E, 32'hAB7E_AB7E, 1);
            put_run(32'hB57E_B57E, 32'hB57E_B57E, 40);
            put_run(32'hEBF4_EBF4, 32'hF4EB_F4EB, 7);
            put_run(32'hF4AB_F4AB, 32'hF4AB_F4AB, 1);
        end
        put(shrt ? 32'hCC08_09CA : 32'hDD09_AE5B, 4'h0, 5);   // R5
        put(32'hBCBC_BCFD, 4'hF, 7);                          // R7
        put(32'h7C7C_7C7C, 4'hF, 7);                          // R7
        it.d = 32'h1C1C_1C1C; it.c = 4'hF; it.last = 1'b1; it.req = 7;
        q.push_back(it);
    endtask

    task automatic kick(input bit shrt);
        @(posedge clk); #1;
        short_i = shrt;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic drain;
        while (q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Ready pattern
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready_i = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
        end
    end

    // Monitor: compare accepted columns, check idle, hold and done
    initial begin
        bit          prev_stall = 1'b0;
        logic [31:0] prev_d = '0;
        logic [3:0]  prev_c = '0;
        col_t        it;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (prev_stall)
                    chk(col_data_o == prev_d && col_ctrl_o == prev_c, 8,
                        {col_ctrl_o, col_data_o}, {prev_c, prev_d}); // R8
                if (!busy_o) begin
                    chk(col_data_o == 32'h1C1C_1C1C && col_ctrl_o == 4'hF, 1,
                        {col_ctrl_o, col_data_o}, {4'hF, 32'h1C1C_1C1C}); // R1
                    chk(q.size() == 0, 11, 36'(q.size()), 36'd0);          // R11 R9
                    chk(done_o == 1'b0, 10, 36'(done_o), 36'd0);            // R10
                end else if (ready_i) begin
                    if (q.size() == 0) begin
                        chk(1'b0, 11, {col_ctrl_o, col_data_o}, 36'd0);    // R11
                    end else begin
                        it = q.pop_front();
                        chk(col_data_o == it.d && col_ctrl_o == it.c, it.req,
                            {col_ctrl_o, col_data_o}, {it.c, it.d});
                        chk(done_o == it.last, 10, 36'(done_o), 36'(it.last)); // R10
                    end
                end else begin
                    chk(done_o == 1'b0, 10, 36'(done_o), 36'd0);           // R10
                end
                prev_stall = busy_o && !ready_i;
                prev_d = col_data_o;
                prev_c = col_ctrl_o;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, 1, {34'd0, busy_o, done_o}, 36'd0);   // R1 reset
        chk(col_data_o == 32'h1C1C_1C1C && col_ctrl_o == 4'hF, 1,
            {col_ctrl_o, col_data_o}, {4'hF, 32'h1C1C_1C1C});                    // R1 reset
        rst_n = 1'b1;
        mon_en = 1'b1;

        // Long single packet, mode toggled mid-packet (R5, R12)
        kick(1'b0);
        push_pkt(1'b0);
        repeat (100) @(posedge clk);
        #1 short_i = 1'b1;
        drain();

        // Short single packet under random stalls (R8)
        stall_en = 1'b1;
        kick(1'b1);
        push_pkt(1'b1);
        short_i = 1'b0;
        drain();

        // Repeat: short then long, back to back (R9, R12)
        repeat_i = 1'b1;
        kick(1'b1);
        push_pkt(1'b1);
        push_pkt(1'b0);
        short_i = 1'b0;
        while (q.size() > 3) @(posedge clk);
        #1 repeat_i = 1'b0;
        drain();

        // Long single packet under stalls
        kick(1'b0);
        push_pkt(1'b0);
        drain();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule